// File: doc/BRIEF.md
# Programmable Video Sync Pulse Combiner

This block produces one user-defined timing output for a video raster. An external raster counter supplies the current pixel count, the current line count, and a flag that marks the odd field. The block holds a horizontal window and a vertical window. The horizontal window is a start pixel and a stop pixel. The vertical window is a start line and a stop line. Each window yields an active indication.

A logical operator picks how the two indications are merged: AND, OR or XOR. The operators have a fixed priority. A polarity stage then sets the output level, and its reset value gives an active-low output.

Software programs the block through a small write/read register port. Reads return the most recently written values. New settings reach the output only at the first pixel of a line, so a write made in the middle of a line cannot cut a pulse short. The output is registered.

Top module: `sync_combiner`

## Requirements
- R1: Addresses 0, 1, 2 and 3 hold the horizontal start pixel, horizontal stop pixel, vertical start line and vertical stop line. Each keeps a 15-bit value in bits 14..0, and bit 15 always reads back as 0.
- R2: The horizontal indication is active while start pixel <= pixel count < stop pixel.
- R3: The vertical indication is active while start line <= line count < stop line. When `interlaced` is high, it is active only while `odd_field` is high. When `interlaced` is low, `odd_field` has no effect.
- R4: When control bit 2 (AND) is 1, the combined signal is H AND V, whatever bits 1 and 0 hold.
- R5: When bit 2 is 0 and bit 1 (OR) is 1, the combined signal is H OR V, whatever bit 0 holds.
- R6: When bit 0 (XOR) is the only operator bit set, the combined signal is active when exactly one of H and V is active.
- R7: When bits 2..0 are all 0, the combined signal is inactive.
- R8: Address 4 is the control register. Bit 3 is polarity: 1 drives `sync_out` low when the combined signal is active, and 0 drives it high. Bits 15..4 read back as 0. Addresses 5 to 7 read as 0, and writes to them change nothing.
- R9: After reset, the four window registers read 0, the control register reads 0x0008, and `sync_out` is 1.
- R10: `sync_out` is registered. It shows the result for the counter values sampled at the previous rising clock edge.
- R11: A write is visible on `rdata` in the next cycle. It affects `sync_out` only from the first cycle in which `pix_cnt` is 0, and that cycle already uses the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_cnt | input | 15 | Current pixel count |
| line_cnt | input | 15 | Current line count |
| odd_field | input | 1 | High during the odd field |
| interlaced | input | 1 | Output format is interlaced |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| sync_out | output | 1 | Combined, polarity-adjusted sync output |

## Verification
The bench sweeps every value of the control register over a small raster. That sweep catches a wrong operator priority, which would show as OR or XOR behaviour leaking in while AND is set, and an inverted polarity default, which would flip every sample. The pixels and lines on either side of each window edge are checked, so an inclusive stop or an exclusive start shows up as a one-pixel or one-line error. Interlaced sweeps with both field values catch a vertical window that ignores the field flag. A write made in the middle of a line must leave the rest of that line unchanged, so a design that applies settings at once would show a runt pulse.

// File: rtl/sync_combiner.sv
module sync_combiner #(
  parameter int CW = 15,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_cnt,
  input  logic [CW-1:0] line_cnt,
  input  logic          odd_field,
  input  logic          interlaced,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          sync_out
);
  localparam int PAD = 16 - CW;

  logic [CW-1:0] p_hs, p_he, p_vs, p_ve;
  logic [CW-1:0] a_hs, a_he, a_vs, a_ve;
  logic [3:0]    p_ctl, a_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hs <= '0; p_he <= '0; p_vs <= '0; p_ve <= '0;
      p_ctl <= 4'b1000;
    end else if (we) begin
      case (addr)
        AW'(0): p_hs  <= wdata[CW-1:0];
        AW'(1): p_he  <= wdata[CW-1:0];
        AW'(2): p_vs  <= wdata[CW-1:0];
        AW'(3): p_ve  <= wdata[CW-1:0];
        AW'(4): p_ctl <= wdata[3:0];
        default: ;
      endcase
    end
  end

  wire line_head = (pix_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hs <= '0; a_he <= '0; a_vs <= '0; a_ve <= '0;
      a_ctl <= 4'b1000;
    end else if (line_head) begin
      a_hs <= p_hs; a_he <= p_he; a_vs <= p_vs; a_ve <= p_ve;
      a_ctl <= p_ctl;
    end
  end

  wire [CW-1:0] e_hs  = line_head ? p_hs  : a_hs;
  wire [CW-1:0] e_he  = line_head ? p_he  : a_he;
  wire [CW-1:0] e_vs  = line_head ? p_vs  : a_vs;
  wire [CW-1:0] e_ve  = line_head ? p_ve  : a_ve;
  wire [3:0]    e_ctl = line_head ? p_ctl : a_ctl;

  wire h_on = (pix_cnt >= e_hs) && (pix_cnt < e_he);
  wire v_on = (line_cnt >= e_vs) && (line_cnt < e_ve) && (!interlaced || odd_field);

  logic merged;
  always_comb begin
    if (e_ctl[2])      merged = h_on & v_on;
    else if (e_ctl[1]) merged = h_on | v_on;
    else if (e_ctl[0]) merged = h_on ^ v_on;
    else               merged = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out <= 1'b1;
    else        sync_out <= merged ^ e_ctl[3];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(0): rdata = {{PAD{1'b0}}, p_hs};
      AW'(1): rdata = {{PAD{1'b0}}, p_he};
      AW'(2): rdata = {{PAD{1'b0}}, p_vs};
      AW'(3): rdata = {{PAD{1'b0}}, p_ve};
      AW'(4): rdata = {12'h000, p_ctl};
      default: rdata = '0;
    endcase
  end
endmodule

module sync_combiner_chk #(
  parameter int CW = 15,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] pix_cnt,
  input logic [AW-1:0] addr,
  input logic [15:0]   rdata,
  input logic          sync_out,
  input logic [3:0]    a_ctl,
  input logic [CW-1:0] a_hs
);
  p_window_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < AW'(4)) |-> (rdata[15] == 1'b0));

  p_ctl_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(4)) |-> (rdata[15:4] == 12'h000));

  p_hold_midline_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != '0) |=> ($stable(a_ctl) && $stable(a_hs)));

  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != '0 && a_ctl[2:0] == 3'b000) |=> (sync_out == $past(a_ctl[3])));

  p_and_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != '0 && a_ctl[2] && pix_cnt < a_hs) |=> (sync_out == $past(a_ctl[3])));
endmodule

bind sync_combiner sync_combiner_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .addr(addr), .rdata(rdata),
  .sync_out(sync_out), .a_ctl(a_ctl), .a_hs(a_hs)
);

// File: tb/tb_sync_combiner.sv
module tb_sync_combiner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] pix_cnt = '0, line_cnt = '0;
  logic odd_field = 1'b0, interlaced = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic sync_out;

  int checks = 0, errors = 0;
  int pend[5], act[5];

  always #10 clk = ~clk;

  sync_combiner dut (.clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .odd_field(odd_field), .interlaced(interlaced), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sync_out(sync_out));

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    addr = 3'(a); wdata = 16'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a < 4) pend[a] = d & 16'h7fff;
    else if (a == 4) pend[4] = d & 16'hf;
  endtask

  function automatic int model(int p, int l, bit odd, bit intl);
    bit h, v, m;
    h = (p >= act[0]) && (p < act[1]);
    v = (l >= act[2]) && (l < act[3]) && (!intl || odd);
    if (act[4][2]) m = h & v;
    else if (act[4][1]) m = h | v;
    else if (act[4][0]) m = h ^ v;
    else m = 1'b0;
    return int'(m ^ act[4][3]);
  endfunction

  function automatic string op_tag(int c);
    if (c[2]) return "R4";
    if (c[1]) return "R5";
    if (c[0]) return "R6";
    return "R7";
  endfunction

  // R2, R3, R8, R10: one registered sample per call
  task automatic step(int p, int l, bit odd, string tag);
    int e;
    pix_cnt = 15'(p); line_cnt = 15'(l); odd_field = odd;
    if (p == 0) act = pend;
    e = model(p, l, odd, interlaced);
    @(negedge clk);
    chk(tag, int'(sync_out), e);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (pend[i]) pend[i] = 0;
    pend[4] = 8;
    act = pend;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", int'(sync_out), 1);
    for (int a = 0; a < 5; a++) begin
      addr = 3'(a); #1;
      chk("R9", int'(rdata), a == 4 ? 8 : 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    pix_cnt = 15'd1;

    // R1 readback and reserved bit
    wr(0, 16'hffff); addr = 3'd0; #1; chk("R1", int'(rdata), 16'h7fff);
    wr(4, 16'hfff5); addr = 3'd4; #1; chk("R8", int'(rdata), 5);
    // R8 unmapped address
    wr(5, 16'h1234); addr = 3'd5; #1; chk("R8", int'(rdata), 0);
    addr = 3'd0; #1; chk("R8", int'(rdata), 16'h7fff);
    addr = 3'd4; #1; chk("R8", int'(rdata), 5);

    wr(0, 3); wr(1, 8); wr(2, 2); wr(3, 5);
    // R4..R8 full control sweep over a 12x8 raster, edges included (R2, R3)
    for (int c = 0; c < 16; c++) begin
      wr(4, c);
      for (int l = 0; l < 8; l++)
        for (int p = 0; p < 12; p++)
          step(p, l, 1'b0, op_tag(c));
    end

    // R3 interlaced gating with both field values
    interlaced = 1'b1;
    wr(4, 16'h0002);
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 8; l++)
        for (int p = 0; p < 12; p++)
          step(p, l, f[0], "R3");
    interlaced = 1'b0;
    for (int l = 0; l < 8; l++)
      step(4, l, 1'b1, "R3");

    // R11 mid-line write deferred to next line start
    wr(4, 16'h0006);
    step(0, 3, 1'b0, "R11");
    step(2, 3, 1'b0, "R11");
    wr(0, 6); wr(4, 16'h000c);
    addr = 3'd0; #1; chk("R11", int'(rdata), 6);
    for (int p = 2; p < 12; p++) step(p, 3, 1'b0, "R11");
    for (int p = 0; p < 12; p++) step(p, 3, 1'b0, "R11");
    for (int p = 0; p < 12; p++) step(p, 6, 1'b0, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule